// File: doc/BRIEF.md
# Indexed codec control register file

This block is the host-facing control register file of an audio codec. The host reaches it through four byte-wide ports selected by a 2-bit address. Port 0 holds the index pointer and the mode-change-enable flag. Port 1 is the data window into a bank of 32 indirect 8-bit control registers. Port 2 holds the interrupt status and port 3 is the programmed-I/O data port. Each indirect register follows its own write rule: fully writable, ignored, single-bit writable, a bit forced to zero, a protected rate/format register, or a flag register that also carries the playback interrupt flags.

The playback engine reads the whole bank through a flat export bus and returns a one-cycle `play_done` pulse when a block finishes. That pulse raises a level interrupt request, which the host clears either through the status port or by clearing the playback flag in the flag register. A small counter imitates an auto-calibration busy bit. When mode-change enable goes from clear to set while calibration is configured, the next read of the error/status register shows bit 5 set.

Top module: `codec_regfile`

## Requirements
- R1: After reset the index port reads 0x40 and the status port reads 0x00, `irq` is low, and the indirect bank holds these values: 0x88 at indices 2, 3, 4, 5, 18 and 19; 0x80 at 6 and 7; 0x08 at 9; 0x8A at 12; 0xA0 at 25 and 26; 0x00 everywhere else.
- R2: A write to the index port (address 0) stores bits 6:0. Bit 7 is dropped and always reads as zero. Bit 6 is the mode-change-enable (MCE) flag.
- R3: The indirect index is the low 4 bits of the index port while bit 6 of register 12 is clear, so index values 16..31 alias 0..15. While that bit is set, the index is the low 5 bits.
- R4: Data writes to registers 11, 22, 27 and 29 leave those registers unchanged.
- R5: In register 12 only bit 6 takes the written value and the other bits keep their contents. A write to register 9 always stores bit 5 as zero.
- R6: A write to register 8 stores the full byte when MCE is set. When MCE is clear and bit 4 of register 24 is set, only bits 7:4 change. When both are clear, the write is dropped.
- R7: An index-port write that sets MCE while the stored MCE is clear, and while bits 4:3 of register 9 are nonzero, arms a calibration counter loaded with 1. Each data-port read of register 11 while the counter is nonzero returns bit 5 set and decrements the counter. An index write with MCE already set does not arm the counter.
- R8: Any write to the status port (address 2) clears status bit 0, clears bits 6:4 of register 24 and drops `irq` on the following cycle.
- R9: A data write to register 24 that clears bit 4 while bit 4 was set clears status bit 0 and `irq`. A write that leaves bit 4 set does not.
- R10: A `play_done` pulse sets status bit 0, sets bit 4 of register 24 and raises `irq` one cycle later. When a status-port write lands in the same cycle, the set wins over the clear.
- R11: Reads of the status and PIO ports have no side effects. Writes to the PIO port (address 3) are ignored, and it always reads 0x00.
- R12: All other indirect registers store the written byte. `ctl_regs` bits 8i+7:8i carry indirect register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe (needed for read side effects) |
| host_addr | input | 2 | Direct port select: 0 index, 1 data, 2 status, 3 PIO |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from current state |
| play_done | input | 1 | Playback-complete pulse from the playback engine |
| irq | output | 1 | Level-high interrupt request |
| ctl_regs | output | NUM_IREG*8 | Flat export of the indirect register bank |

## Verification
The interrupt flag can be set by a `play_done` pulse and cleared by a host status-port write in the same clock cycle. The bench provokes this by asserting both strobes on one edge while the flag is already set. It then expects `irq` and status bit 0 to stay high, and register 24 to read back with bits 6:5 cleared and bit 4 set. All other register contents are checked by sweeping every index with distinct byte patterns against a bench-side model of the write rules.

// File: rtl/codec_regfile_pkg.sv
// Shared constants, write-rule classes and reset values for the codec
// control register file. Assumes a 32-entry indirect bank.
package codec_regfile_pkg;

    localparam int REG_W = 8;

    // Direct port selects on the host address.
    localparam logic [1:0] PORT_INDEX  = 2'd0;
    localparam logic [1:0] PORT_DATA   = 2'd1;
    localparam logic [1:0] PORT_STATUS = 2'd2;
    localparam logic [1:0] PORT_PIO    = 2'd3;

    // Indirect indices whose behaviour is special.
    localparam int IX_FMT   = 8;
    localparam int IX_CFG   = 9;
    localparam int IX_ERRST = 11;
    localparam int IX_MODE  = 12;
    localparam int IX_AFS   = 24;

    // Bit positions.
    localparam int MCE_BIT      = 6;
    localparam int MODE2_BIT    = 6;
    localparam int CFG_RSVD_BIT = 5;
    localparam int PI_BIT       = 4;
    localparam int CAL_FLAG_BIT = 5;
    localparam logic [REG_W-1:0] FLAG_MASK = 8'h70;

    // Write-rule class of an indirect register.
    typedef enum logic [2:0] {
        WR_PLAIN,
        WR_IGNORE,
        WR_MODE_ONLY,
        WR_CFG,
        WR_FMT,
        WR_FLAGS
    } wr_rule_e;

    // Reset value of indirect register i.
    function automatic logic [REG_W-1:0] reset_value(input int i);
        case (i)
            2, 3, 4, 5, 18, 19: reset_value = 8'h88;
            6, 7:               reset_value = 8'h80;
            9:                  reset_value = 8'h08;
            12:                 reset_value = 8'h8A;
            25, 26:             reset_value = 8'hA0;
            default:            reset_value = 8'h00;
        endcase
    endfunction

    // Write rule that applies to indirect register i.
    function automatic wr_rule_e rule_of(input int i);
        case (i)
            11, 22, 27, 29: rule_of = WR_IGNORE;
            12:             rule_of = WR_MODE_ONLY;
            9:              rule_of = WR_CFG;
            8:              rule_of = WR_FMT;
            24:             rule_of = WR_FLAGS;
            default:        rule_of = WR_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/codec_index_port.sv
// Index pointer register and calibration-busy counter.
// Holds the 7 stored bits of the index port (bit 6 = MCE) and arms a
// counter on a clear-to-set MCE transition when calibration is configured.
// Assumes at most one host access per cycle.
module codec_index_port
    import codec_regfile_pkg::*;
#(
    parameter int CAL_W    = 2,
    parameter int CAL_LOAD = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [6:0] wdata_i,
    input  logic       cal_arm_i,
    input  logic       cal_rd_i,
    output logic [6:0] index_o,
    output logic       cal_busy_o
);

    localparam logic [6:0]       INDEX_RST = 7'h40;
    localparam logic [CAL_W-1:0] CAL_INIT  = CAL_W'(CAL_LOAD);

    logic [6:0]       idx_q;
    logic [CAL_W-1:0] cal_cnt;
    logic             mce_rise;

    // Detect an MCE clear-to-set write.
    always_comb mce_rise = wr_i && !idx_q[MCE_BIT] && wdata_i[MCE_BIT];

    // Index pointer storage.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= INDEX_RST;
        else if (wr_i) idx_q <= wdata_i;
    end

    // Calibration counter: load on MCE rise, count down on flagged reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cal_cnt <= '0;
        else if (mce_rise && cal_arm_i)      cal_cnt <= CAL_INIT;
        else if (cal_rd_i && cal_cnt != '0)  cal_cnt <= cal_cnt - 1'b1;
    end

    assign index_o    = idx_q;
    assign cal_busy_o = (cal_cnt != '0);

    // R7
    cal_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy_o && cal_rd_i && !wr_i) |=> (cal_cnt == $past(cal_cnt) - 1'b1));

    // R7
    cal_no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && idx_q[MCE_BIT] && !cal_busy_o && !cal_rd_i) |=> !cal_busy_o);

endmodule

// File: rtl/codec_reg_bank.sv
// Indirect control register bank.
// One generated register per index, each with the write rule chosen from the
// package. Register 24 also takes the playback flag set and the status clear.
// Assumes NUM_IREG = 32 so that indices 8, 9, 12 and 24 exist.
module codec_reg_bank
    import codec_regfile_pkg::*;
#(
    parameter int NUM_IREG = 32,
    localparam int IDX_W   = $clog2(NUM_IREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [REG_W-1:0]               wdata_i,
    input  logic                           mce_i,
    input  logic                           flags_clr_i,
    input  logic                           pi_set_i,
    output logic [NUM_IREG-1:0][REG_W-1:0] regs_o,
    output logic                           pi_drop_o
);

    logic pmce;

    // Bit 4 of the flag register doubles as the partial-change enable.
    always_comb pmce = regs_o[IX_AFS][PI_BIT];

    // Host write to the flag register that clears a set PI bit.
    always_comb pi_drop_o = wr_i && (idx_i == IDX_W'(IX_AFS)) &&
                            regs_o[IX_AFS][PI_BIT] && !wdata_i[PI_BIT];

    for (genvar g = 0; g < NUM_IREG; g++) begin : g_reg
        localparam wr_rule_e         RULE = rule_of(g);
        localparam logic [REG_W-1:0] RST  = reset_value(g);

        logic [REG_W-1:0] q;
        logic [REG_W-1:0] nxt;
        logic             hit;

        // Decode a host data write to this index.
        always_comb hit = wr_i && (idx_i == IDX_W'(g));

        // Next value under this register's write rule.
        always_comb begin
            nxt = q;
            if (RULE == WR_PLAIN) begin
                if (hit) nxt = wdata_i;
            end else if (RULE == WR_MODE_ONLY) begin
                if (hit) nxt[MODE2_BIT] = wdata_i[MODE2_BIT];
            end else if (RULE == WR_CFG) begin
                if (hit) begin
                    nxt = wdata_i;
                    nxt[CFG_RSVD_BIT] = 1'b0;
                end
            end else if (RULE == WR_FMT) begin
                if (hit && mce_i)      nxt = wdata_i;
                else if (hit && pmce)  nxt = {wdata_i[7:4], q[3:0]};
            end else if (RULE == WR_FLAGS) begin
                if (hit)         nxt = wdata_i;
                if (flags_clr_i) nxt = nxt & ~FLAG_MASK;
                if (pi_set_i)    nxt[PI_BIT] = 1'b1;
            end
        end

        // Register storage.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= RST;
            else        q <= nxt;
        end

        assign regs_o[g] = q;

        if (RULE == WR_FMT) begin : g_fmt_chk
            // R6
            fmt_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && !mce_i && pmce) |=>
                    (q[3:0] == $past(q[3:0])) && (q[7:4] == $past(wdata_i[7:4])));
            // R6
            fmt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!mce_i && !pmce) |=> $stable(q));
        end

        if (RULE == WR_FLAGS) begin : g_flag_chk
            // R10
            flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pi_set_i |=> q[PI_BIT]);
        end
    end

endmodule

// File: rtl/codec_int_ctrl.sv
// Status INT bit and interrupt request.
// Set by the playback-complete pulse, cleared by a status-port write or by a
// host write that drops PI in the flag register; set has priority.
module codec_int_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pi_set_i,
    input  logic status_wr_i,
    input  logic pi_drop_i,
    output logic int_o
);

    logic int_q;

    // Interrupt flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                        int_q <= 1'b0;
        else if (pi_set_i)                 int_q <= 1'b1;
        else if (status_wr_i || pi_drop_i) int_q <= 1'b0;
    end

    assign int_o = int_q;

    // R10
    done_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pi_set_i |=> int_o);

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr_i && !pi_set_i) |=> !int_o);

    // R9
    pi_drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pi_drop_i && !pi_set_i) |=> !int_o);

endmodule

// File: rtl/codec_regfile.sv
// Indexed codec control register file, top level.
// Decodes the four byte-wide host ports, forms the 4- or 5-bit indirect index,
// muxes read data and exports the bank to the playback engine.
// Assumes host_wr and host_rd are never asserted in the same cycle.
module codec_regfile
    import codec_regfile_pkg::*;
#(
    parameter int NUM_IREG = 32,
    parameter int CAL_W    = 2,
    parameter int CAL_LOAD = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_wr,
    input  logic                      host_rd,
    input  logic [1:0]                host_addr,
    input  logic [7:0]                host_wdata,
    output logic [7:0]                host_rdata,
    input  logic                      play_done,
    output logic                      irq,
    output logic [NUM_IREG*REG_W-1:0] ctl_regs
);

    localparam int IDX_W = $clog2(NUM_IREG);
    localparam logic [REG_W-1:0] PIO_VALUE = 8'h00;

    logic [6:0]                     index_q;
    logic                           cal_busy;
    logic [NUM_IREG-1:0][REG_W-1:0] bank;
    logic [IDX_W-1:0]               ind_idx;
    logic                           mode2;
    logic                           wr_index, wr_data, wr_status, rd_data;
    logic                           cal_rd, cal_arm, pi_drop, int_flag;
    logic [REG_W-1:0]               data_rd;

    // Host strobe decode per direct port.
    always_comb begin
        wr_index  = host_wr && (host_addr == PORT_INDEX);
        wr_data   = host_wr && (host_addr == PORT_DATA);
        wr_status = host_wr && (host_addr == PORT_STATUS);
        rd_data   = host_rd && (host_addr == PORT_DATA);
    end

    // Indirect index: upper bit masked unless the extended mode is on.
    always_comb begin
        mode2   = bank[IX_MODE][MODE2_BIT];
        ind_idx = index_q[IDX_W-1:0];
        if (!mode2) ind_idx[IDX_W-1:4] = '0;
    end

    // Calibration configured and calibration-flag read detection.
    always_comb begin
        cal_arm = (bank[IX_CFG][4:3] != 2'b00);
        cal_rd  = rd_data && (ind_idx == IDX_W'(IX_ERRST));
    end

    codec_index_port #(
        .CAL_W    (CAL_W),
        .CAL_LOAD (CAL_LOAD)
    ) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_index),
        .wdata_i    (host_wdata[6:0]),
        .cal_arm_i  (cal_arm),
        .cal_rd_i   (cal_rd),
        .index_o    (index_q),
        .cal_busy_o (cal_busy)
    );

    codec_reg_bank #(
        .NUM_IREG (NUM_IREG)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_data),
        .idx_i       (ind_idx),
        .wdata_i     (host_wdata),
        .mce_i       (index_q[MCE_BIT]),
        .flags_clr_i (wr_status),
        .pi_set_i    (play_done),
        .regs_o      (bank),
        .pi_drop_o   (pi_drop)
    );

    codec_int_ctrl u_int (
        .clk         (clk),
        .rst_n       (rst_n),
        .pi_set_i    (play_done),
        .status_wr_i (wr_status),
        .pi_drop_i   (pi_drop),
        .int_o       (int_flag)
    );

    // Indexed data read with the calibration flag merged in.
    always_comb begin
        data_rd = bank[ind_idx];
        if (cal_rd && cal_busy) data_rd[CAL_FLAG_BIT] = 1'b1;
    end

    // Direct port read mux.
    always_comb begin
        case (host_addr)
            PORT_INDEX:  host_rdata = {1'b0, index_q};
            PORT_DATA:   host_rdata = data_rd;
            PORT_STATUS: host_rdata = {7'b0, int_flag};
            default:     host_rdata = PIO_VALUE;
        endcase
    end

    assign irq      = int_flag;
    assign ctl_regs = bank;

    // R2
    index_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == PORT_INDEX) |-> (host_rdata[7] == 1'b0));

    // R3
    narrow_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank[IX_MODE][MODE2_BIT]) |-> (ind_idx[IDX_W-1] == 1'b0));

    // R8
    status_port_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !play_done) |=> (bank[IX_AFS][6:4] == 3'b000) && !irq);

endmodule

// File: tb/codec_regfile_test.sv
module codec_regfile_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_wr = 1'b0;
    logic         host_rd = 1'b0;
    logic [1:0]   host_addr = 2'd0;
    logic [7:0]   host_wdata = 8'd0;
    logic [7:0]   host_rdata;
    logic         play_done = 1'b0;
    logic         irq;
    logic [255:0] ctl_regs;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    // Bench-side model of the register file.
    logic [7:0] m_reg [32];
    logic [6:0] m_idx;
    logic       m_int;
    logic       m_cal;

    always #2 clk = ~clk;

    codec_regfile uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .play_done  (play_done),
        .irq        (irq),
        .ctl_regs   (ctl_regs)
    );

    function automatic logic [7:0] rst_val(input int i);
        if (i >= 2 && i <= 5)      return 8'h88;
        if (i == 18 || i == 19)    return 8'h88;
        if (i == 6 || i == 7)      return 8'h80;
        if (i == 9)                return 8'h08;
        if (i == 12)               return 8'h8A;
        if (i == 25 || i == 26)    return 8'hA0;
        return 8'h00;
    endfunction

    function automatic int cur_ind();
        if (m_reg[12][6]) return int'(m_idx[4:0]);
        return int'(m_idx[3:0]);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd_port(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic set_index(input logic [7:0] v);
        if (!m_idx[6] && v[6] && (m_reg[9][4:3] != 2'b00)) m_cal = 1'b1;
        m_idx = v[6:0];
        wr_port(2'd0, v);
    endtask

    task automatic wr_ind(input logic [7:0] v);
        int i;
        i = cur_ind();
        case (i)
            11, 22, 27, 29: ;
            12: m_reg[12][6] = v[6];
            9:  m_reg[9] = v & 8'hDF;
            8: begin
                if (m_idx[6])          m_reg[8] = v;
                else if (m_reg[24][4]) m_reg[8] = {v[7:4], m_reg[8][3:0]};
            end
            24: begin
                if (m_reg[24][4] && !v[4]) m_int = 1'b0;
                m_reg[24] = v;
            end
            default: m_reg[i] = v;
        endcase
        wr_port(2'd1, v);
    endtask

    task automatic chk_ind(input string req);
        logic [7:0] d, e;
        int i;
        i = cur_ind();
        e = m_reg[i];
        if (i == 11 && m_cal) begin
            e[5] = 1'b1;
            m_cal = 1'b0;
        end
        rd_port(2'd1, d);
        check(req, d, e);
    endtask

    task automatic status_write();
        m_int = 1'b0;
        m_reg[24] = m_reg[24] & 8'h8F;
        wr_port(2'd2, 8'hFF);
    endtask

    task automatic pulse_done(input bit with_status);
        @(negedge clk);
        play_done = 1'b1;
        if (with_status) begin
            host_addr = 2'd2; host_wr = 1'b1;
            m_reg[24] = m_reg[24] & 8'h8F;
        end
        m_reg[24][4] = 1'b1;
        m_int = 1'b1;
        @(posedge clk); #1;
        play_done = 1'b0; host_wr = 1'b0;
    endtask

    task automatic chk_irq_status(input string req);
        logic [7:0] d;
        check(req, {7'b0, irq}, {7'b0, m_int});
        rd_port(2'd2, d);
        check(req, d, {7'b0, m_int});
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, e;
        for (int i = 0; i < 32; i++) m_reg[i] = rst_val(i);
        m_idx = 7'h40; m_int = 1'b0; m_cal = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        rd_port(2'd0, d); check("R1 index", d, 8'h40);
        chk_irq_status("R1 status");
        for (int i = 0; i < 32; i++)
            check("R1 bank", ctl_regs[i*8 +: 8], rst_val(i));
        for (int i = 0; i < 16; i++) begin
            set_index(8'h40 | 8'(i));
            chk_ind("R1 read");
        end

        // R5: register 12 only bit 6 writable; turn on wide index
        set_index(8'h4C); wr_ind(8'hFF);
        chk_ind("R5 mode");
        check("R5 mode lit", m_reg[12], 8'hCA);

        // R12/R4/R5: sweep every index with MCE set
        for (int i = 0; i < 32; i++) begin
            logic [7:0] p;
            p = 8'((i * 29 + 8'h35) & 8'hFF);
            if (i == 12) p = p | 8'h40;
            if (i == 24) p = p & 8'hEF;
            set_index(8'h40 | 8'(i));
            wr_ind(p);
        end
        for (int i = 0; i < 32; i++) begin
            set_index(8'h40 | 8'(i));
            chk_ind("R12 sweep");
            check("R12 export", ctl_regs[i*8 +: 8], m_reg[i]);
        end
        check("R4 reserved22", ctl_regs[22*8 +: 8], 8'h00);
        check("R5 cfg bit5", {7'b0, ctl_regs[9*8+5]}, 8'h00);

        // R2: bit 7 of the index port
        wr_port(2'd0, 8'hFF); m_idx = 7'h7F;
        rd_port(2'd0, d); check("R2 index", d, 8'h7F);

        // R3: narrow index aliasing
        set_index(8'h4C); wr_ind(8'h00);
        set_index(8'h5C);
        chk_ind("R3 alias");
        wr_ind(8'h40);
        check("R3 alias wr", ctl_regs[12*8 +: 8], 8'hCA);
        set_index(8'h5C);
        chk_ind("R3 wide");

        // R6: format register gating
        set_index(8'h58); wr_ind(8'h10);
        set_index(8'h08); wr_ind(8'hA7);
        chk_ind("R6 partial");
        set_index(8'h18); wr_ind(8'h00);
        set_index(8'h08); wr_ind(8'h3C);
        chk_ind("R6 dropped");
        set_index(8'h48); wr_ind(8'h5B);
        chk_ind("R6 full");
        check("R6 full lit", m_reg[8], 8'h5B);
        set_index(8'h4B); chk_ind("R7 flush");

        // R7: calibration flag
        set_index(8'h09); wr_ind(8'h08);
        set_index(8'h0B); set_index(8'h4B);
        rd_port(2'd1, d); check("R7 busy", d, 8'h20); m_cal = 1'b0;
        rd_port(2'd1, d); check("R7 done", d, 8'h00);
        set_index(8'h09); wr_ind(8'h00);
        set_index(8'h0B); set_index(8'h4B);
        rd_port(2'd1, d); check("R7 unarmed", d, 8'h00);
        set_index(8'h49); wr_ind(8'h18);
        set_index(8'h4B);
        rd_port(2'd1, d); check("R7 no rise", d, 8'h00);

        // R10 then R8
        set_index(8'h58); wr_ind(8'h60);
        pulse_done(1'b0);
        chk_irq_status("R10 set");
        chk_ind("R10 flags");
        status_write();
        chk_irq_status("R8 clear");
        chk_ind("R8 flags");

        // R9
        pulse_done(1'b0);
        wr_ind(8'h30);
        chk_irq_status("R9 keep");
        wr_ind(8'h20);
        chk_irq_status("R9 drop");
        chk_ind("R9 flags");

        // R10: same-cycle set and clear
        pulse_done(1'b0);
        pulse_done(1'b1);
        chk_irq_status("R10 collide");
        chk_ind("R10 collide flags");
        check("R10 collide lit", m_reg[24], 8'h10);

        // R11: reads without side effects, PIO ignored
        rd_port(2'd2, d); rd_port(2'd2, e);
        check("R11 status stable", e, d);
        wr_port(2'd3, 8'hFF);
        rd_port(2'd3, d); check("R11 pio", d, 8'h00);
        check("R11 irq", {7'b0, irq}, 8'h01);
        rd_port(2'd0, d); check("R11 index", d, {1'b0, m_idx});
        chk_ind("R11 flags");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule